// File: doc/BRIEF.md
# Single-Channel Block DMA Sequencer

This block is the control engine of one DMA channel. It keeps the working source and destination addresses, the words to move per start, a total word budget, an inter-block wait setting and a fill word. It turns these into a stream of 32-bit read and write requests on a simple request/grant bus. Every word is read from the source and then written to the destination. In fill mode there is no read, and the fill word is written instead. Words are grouped into blocks of a power-of-two size. The request line drops at every block boundary so that an external arbiter can hand the bus to another channel. After each block the channel waits a programmable, prescaled interval before the next block.

A run starts in one of three ways. In immediate mode it starts as soon as the control word is written, and the channel finishes after one run. In repeat mode it starts on every pulse of the selected trigger, and the channel stays armed. In counted mode it also starts on every selected trigger pulse, and the channel retires once the accumulated word count reaches the total budget. A 4-bit field in the control word selects one of 16 trigger inputs. Register decode, arbitration between channels and the real trigger sources are outside this block. A register is written by presenting its select code with `reg_we` high for one cycle.

States: `ST_IDLE` (disarmed), `ST_WAIT_TRIG` (armed, waiting for the selected trigger), `ST_LOAD_RUN` (loads the run and first-block counts), `ST_READ` (source read beat), `ST_WRITE` (destination write beat), `ST_GAP` (inter-block wait) and `ST_RUN_END` (reload, update the total, decide whether to finish). Transitions:
- IDLE→LOAD_RUN on a control write with enable and immediate set. IDLE→WAIT_TRIG on a control write with enable set and immediate clear. A control write with enable clear from any state goes to IDLE.
- WAIT_TRIG→LOAD_RUN on the selected trigger.
- LOAD_RUN→READ (or WRITE in fill mode), or →RUN_END if the run count is zero.
- READ→WRITE on grant.
- WRITE→READ/WRITE on grant when words remain in the block. WRITE→GAP on grant at the end of a block when words remain in the run. WRITE→RUN_END on grant at the last word of the run.
- GAP→READ/WRITE when the wait expires.
- RUN_END→IDLE when finished, else →WAIT_TRIG.

Top module: `dma_chan_seq`

Register select codes on `reg_sel`:

| Code | Register |
|------|----------|
| 0 | source address |
| 1 | destination address |
| 2 | total word budget (bits 27:0) |
| 3 | words per run (bits 23:0) |
| 4 | wait count N (bits 15:0) and prescale (bits 17:16) |
| 5 | fill word |
| 6 | control word |

Control word fields:

| Bits | Field |
|------|-------|
| 31 | enable |
| 30 | interrupt enable |
| 29 | repeat |
| 28 | immediate |
| 27:24 | trigger select |
| 19:16 | block size exponent |
| 15 | source reload |
| 14:13 | source mode |
| 12 | destination reload |
| 11:10 | destination mode |

## Requirements
- R1: After reset `busy`, `bus_req` and `irq` are all 0.
- R2: A written address has its two low bits cleared, and every address presented on `bus_addr` is word aligned.
- R3: Source mode (control bits 14:13) and destination mode (bits 11:10) use the same encoding: 0 adds 4, 1 subtracts 4 and 2 leaves the address unchanged after each word.
- R4: Source mode 3 is fill mode. No read beat is issued, and each write carries the fill word.
- R5: A block holds 2^k words, where k is control bits 19:16. The last block of a run holds the remaining words. `bus_req` is low in the cycle after the last write of every block.
- R6: Between two blocks of one run, `bus_req` stays low for exactly 1 + N·D cycles. N is the wait count, and D is 1, 4, 16 or 64 for prescale values 0 to 3.
- R7: With immediate (bit 28) set, the run starts without a trigger and the first request is raised in the second cycle after the control write. The channel moves exactly the words-per-run and then clears `busy`, whatever the repeat bit and the total budget hold.
- R8: With repeat (bit 29) set and immediate clear, each pulse on the selected trigger moves the words-per-run, and `busy` never clears by itself.
- R9: With both mode bits clear, each selected trigger pulse moves the words-per-run. `busy` clears after the run in which the accumulated word count first reaches or passes the total budget.
- R10: Trigger pulses on inputs other than the one selected by bits 27:24, and pulses that arrive while a run is in progress, start no transfer.
- R11: With a reload flag set (bit 15 for source, bit 12 for destination), that address returns to its last written value at the end of each run. Without the flag it continues from where the run stopped.
- R12: With interrupt enable (bit 30) set, `irq` is high for exactly one cycle when the channel clears `busy` by itself. There is no pulse when bit 30 is clear, or when a control write with enable clear stops the channel.
- R13: A beat holds `bus_req`, `bus_we` and `bus_addr` until `bus_grant`. A write that follows a read carries the data captured when the read was granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 32 | Register write data |
| trig_vec | input | 16 | Trigger event inputs, one pulse per event |
| bus_req | output | 1 | Bus beat request |
| bus_we | output | 1 | 1 = write beat, 0 = read beat |
| bus_addr | output | 32 | Beat byte address |
| bus_wdata | output | 32 | Write beat data |
| bus_grant | input | 1 | Beat accepted in this cycle |
| bus_rdata | input | 32 | Read data, valid while a read beat is granted |
| busy | output | 1 | Channel armed or transferring |
| irq | output | 1 | One-cycle completion pulse |

## Verification
A control write or a trigger is taken on one clock edge. The next edge moves the channel into the load state, so the first request is visible in the second cycle after the stimulus. The bench samples `bus_req` at exactly those two points. Inter-block waits are measured at the bus as runs of sampled-low request cycles and compared with 1 + N·D. Completion takes two edges after the last granted write: one for the run-end state and one for the registered interrupt. The bench therefore compares word counts, addresses, data, `busy` and the interrupt count only after a settling wait that covers the longest run, or after polling `busy` low. Trigger pulses that should be ignored are placed while the channel is provably mid-run, by waiting for the first granted write of a run that has a long wait.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int TRIG_SEL_W = 4;
    localparam int TRIG_N     = 1 << TRIG_SEL_W;

    typedef enum logic [1:0] {
        AM_INC  = 2'd0,
        AM_DEC  = 2'd1,
        AM_FIX  = 2'd2,
        AM_NONE = 2'd3
    } addr_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WAIT_TRIG = 3'd1,
        ST_LOAD_RUN  = 3'd2,
        ST_READ      = 3'd3,
        ST_WRITE     = 3'd4,
        ST_GAP       = 3'd5,
        ST_RUN_END   = 3'd6
    } chan_state_e;

    typedef enum logic [2:0] {
        SEL_SRC   = 3'd0,
        SEL_DST   = 3'd1,
        SEL_TOTAL = 3'd2,
        SEL_RUN   = 3'd3,
        SEL_IVL   = 3'd4,
        SEL_FILL  = 3'd5,
        SEL_CTRL  = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic                  irq_en;
        logic                  repeat_md;
        logic                  immed;
        logic [TRIG_SEL_W-1:0] trig_sel;
        logic [3:0]            blk_log2;
        logic                  src_reload;
        addr_mode_e            src_mode;
        logic                  dst_reload;
        addr_mode_e            dst_mode;
    } chan_ctrl_t;

    function automatic chan_ctrl_t decode_ctrl(input logic [31:0] w);
        chan_ctrl_t c;
        c.irq_en     = w[30];
        c.repeat_md  = w[29];
        c.immed      = w[28];
        c.trig_sel   = w[27:24];
        c.blk_log2   = w[19:16];
        c.src_reload = w[15];
        c.src_mode   = addr_mode_e'(w[14:13]);
        c.dst_reload = w[12];
        c.dst_mode   = addr_mode_e'(w[11:10]);
        return c;
    endfunction

endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int STEP_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic              reload,
    input  addr_mode_e        mode,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP_BYTES);
    localparam logic [ADDR_W-1:0] MASK_V = ~(STEP_V - 1'b1);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] work_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            work_q <= '0;
        end else if (load) begin
            base_q <= load_val & MASK_V;
            work_q <= load_val & MASK_V;
        end else if (reload) begin
            work_q <= base_q;
        end else if (step) begin
            unique case (mode)
                AM_INC:  work_q <= work_q + STEP_V;
                AM_DEC:  work_q <= work_q - STEP_V;
                AM_FIX:  work_q <= work_q;
                AM_NONE: work_q <= work_q;
                default: work_q <= work_q;
            endcase
        end
    end

    assign addr = work_q;

    // R2: the working address never leaves word alignment
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (addr & ~MASK_V) == '0);

    // R3: increment, decrement and fixed stepping
    a_r3_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !reload && mode == AM_INC) |=> addr == $past(addr) + STEP_V);
    a_r3_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !reload && mode == AM_DEC) |=> addr == $past(addr) - STEP_V);
    a_r3_fix_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !reload && mode == AM_FIX) |=> $stable(addr));

endmodule

// File: rtl/dma_gap_timer.sv
module dma_gap_timer #(
    parameter int IVL_W = 16,
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IVL_W-1:0] ivl,
    input  logic [PRE_W-1:0] pre_sel,
    output logic             done
);

    // prescale divides by 4**pre_sel; counter wide enough for the largest
    localparam int PCW = 2 * ((1 << PRE_W) - 1);

    logic [IVL_W-1:0] cnt_q;
    logic [PCW-1:0]   pre_q;
    logic [PCW-1:0]   div_m1;

    always_comb begin
        div_m1 = '0;
        for (int i = 0; i < PCW; i++) begin
            div_m1[i] = (i < 2 * int'(pre_sel));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else if (start) begin
            cnt_q <= ivl;
            pre_q <= '0;
        end else if (cnt_q != '0) begin
            if (pre_q >= div_m1) begin
                pre_q <= '0;
                cnt_q <= cnt_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign done = (cnt_q == '0);

    // R6: once started with a non-zero count, done stays low in the next cycle
    a_r6_wait_begins: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ivl != '0) |=> !done);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int RUN_W   = 24,
    parameter int TOTAL_W = 28,
    parameter int IVL_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [2:0]          reg_sel,
    input  logic [31:0]         reg_wdata,
    input  logic [TRIG_N-1:0]   trig_vec,
    output logic                bus_req,
    output logic                bus_we,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [31:0]         bus_wdata,
    input  logic                bus_grant,
    input  logic [31:0]         bus_rdata,
    output logic                busy,
    output logic                irq
);

    localparam int SUM_W = TOTAL_W + 1;
    localparam int PRE_W = 2;
    localparam int N_AU  = 2;   // 0: source, 1: destination

    // ---------------- configuration registers ----------------
    chan_ctrl_t         ctrl_q;
    logic [RUN_W-1:0]   run_cnt_q;
    logic [TOTAL_W-1:0] total_q;
    logic [IVL_W-1:0]   ivl_q;
    logic [PRE_W-1:0]   pre_q;
    logic [31:0]        fill_q;

    reg_sel_e sel;
    logic     wr_ctrl;
    logic     wr_en_bit;
    logic     wr_imm_bit;

    assign sel        = reg_sel_e'(reg_sel);
    assign wr_ctrl    = reg_we && (sel == SEL_CTRL);
    assign wr_en_bit  = reg_wdata[31];
    assign wr_imm_bit = reg_wdata[28];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            run_cnt_q <= '0;
            total_q   <= '0;
            ivl_q     <= '0;
            pre_q     <= '0;
            fill_q    <= '0;
        end else if (reg_we) begin
            unique case (sel)
                SEL_TOTAL: total_q   <= reg_wdata[TOTAL_W-1:0];
                SEL_RUN:   run_cnt_q <= reg_wdata[RUN_W-1:0];
                SEL_IVL: begin
                    ivl_q <= reg_wdata[IVL_W-1:0];
                    pre_q <= reg_wdata[17:16];
                end
                SEL_FILL:  fill_q    <= reg_wdata;
                SEL_CTRL:  ctrl_q    <= decode_ctrl(reg_wdata);
                default: ;
            endcase
        end
    end

    // ---------------- sequencing state ----------------
    chan_state_e      state_q, state_d;
    logic [RUN_W-1:0] run_left_q;
    logic [RUN_W-1:0] blk_left_q;
    logic [SUM_W-1:0] done_words_q;
    logic [SUM_W-1:0] done_sum;
    logic [31:0]      rd_buf_q;
    logic             irq_q;

    logic             fill_md;
    logic             trig_hit;
    logic             gap_done;
    logic             beat_ok;
    logic             blk_last;
    logic             run_last;
    logic             finish;
    logic             gap_start;
    logic [RUN_W-1:0] blk_words;
    logic [RUN_W-1:0] first_len;
    logic [RUN_W-1:0] next_len;
    chan_state_e      beat_st;

    assign fill_md   = (ctrl_q.src_mode == AM_NONE);
    assign beat_st   = fill_md ? ST_WRITE : ST_READ;
    assign trig_hit  = trig_vec[ctrl_q.trig_sel];
    assign beat_ok   = (state_q == ST_WRITE) && bus_grant;
    assign blk_last  = (blk_left_q == RUN_W'(1));
    assign run_last  = (run_left_q == RUN_W'(1));
    assign gap_start = beat_ok && blk_last && !run_last;
    assign blk_words = RUN_W'(1) << ctrl_q.blk_log2;
    assign first_len = (run_cnt_q < blk_words) ? run_cnt_q : blk_words;
    assign next_len  = (run_left_q < blk_words) ? run_left_q : blk_words;
    assign done_sum  = done_words_q + SUM_W'(run_cnt_q);
    assign finish    = ctrl_q.immed ||
                       (!ctrl_q.repeat_md && (done_sum >= SUM_W'(total_q)));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      state_d = ST_IDLE;
            ST_WAIT_TRIG: if (trig_hit) state_d = ST_LOAD_RUN;
            ST_LOAD_RUN:  state_d = (run_cnt_q == '0) ? ST_RUN_END : beat_st;
            ST_READ:      if (bus_grant) state_d = ST_WRITE;
            ST_WRITE: begin
                if (bus_grant) begin
                    if (!blk_last)     state_d = beat_st;
                    else if (run_last) state_d = ST_RUN_END;
                    else               state_d = ST_GAP;
                end
            end
            ST_GAP:       if (gap_done) state_d = beat_st;
            ST_RUN_END:   state_d = finish ? ST_IDLE : ST_WAIT_TRIG;
            default:      state_d = ST_IDLE;
        endcase
        if (wr_ctrl) begin
            if (!wr_en_bit)      state_d = ST_IDLE;
            else if (wr_imm_bit) state_d = ST_LOAD_RUN;
            else                 state_d = ST_WAIT_TRIG;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters, read buffer and interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_left_q   <= '0;
            blk_left_q   <= '0;
            done_words_q <= '0;
            rd_buf_q     <= '0;
            irq_q        <= 1'b0;
        end else begin
            irq_q <= (state_q == ST_RUN_END) && finish && ctrl_q.irq_en && !wr_ctrl;
            if (wr_ctrl) begin
                done_words_q <= '0;
            end else begin
                unique case (state_q)
                    ST_LOAD_RUN: begin
                        run_left_q <= run_cnt_q;
                        blk_left_q <= first_len;
                    end
                    ST_READ: if (bus_grant) rd_buf_q <= bus_rdata;
                    ST_WRITE: begin
                        if (bus_grant) begin
                            run_left_q <= run_left_q - 1'b1;
                            blk_left_q <= blk_left_q - 1'b1;
                        end
                    end
                    ST_GAP:     if (gap_done) blk_left_q <= next_len;
                    ST_RUN_END: done_words_q <= done_sum;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- address units ----------------
    logic [N_AU-1:0]   au_load;
    logic [N_AU-1:0]   au_step;
    logic [N_AU-1:0]   au_reload;
    addr_mode_e        au_mode [N_AU];
    logic [ADDR_W-1:0] au_addr [N_AU];

    assign au_load[0]   = reg_we && (sel == SEL_SRC);
    assign au_load[1]   = reg_we && (sel == SEL_DST);
    assign au_step[0]   = beat_ok && !fill_md;
    assign au_step[1]   = beat_ok;
    assign au_reload[0] = (state_q == ST_RUN_END) && ctrl_q.src_reload;
    assign au_reload[1] = (state_q == ST_RUN_END) && ctrl_q.dst_reload;
    assign au_mode[0]   = ctrl_q.src_mode;
    assign au_mode[1]   = (ctrl_q.dst_mode == AM_NONE) ? AM_FIX : ctrl_q.dst_mode;

    for (genvar g = 0; g < N_AU; g++) begin : g_au
        dma_addr_unit #(
            .ADDR_W     (ADDR_W),
            .STEP_BYTES (4)
        ) u_addr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (au_load[g]),
            .load_val (reg_wdata[ADDR_W-1:0]),
            .step     (au_step[g]),
            .reload   (au_reload[g]),
            .mode     (au_mode[g]),
            .addr     (au_addr[g])
        );
    end

    // ---------------- inter-block wait ----------------
    dma_gap_timer #(
        .IVL_W (IVL_W),
        .PRE_W (PRE_W)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (gap_start),
        .ivl     (ivl_q),
        .pre_sel (pre_q),
        .done    (gap_done)
    );

    // ---------------- outputs ----------------
    always_comb begin
        bus_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
        bus_we    = (state_q == ST_WRITE);
        bus_addr  = (state_q == ST_WRITE) ? au_addr[1] : au_addr[0];
        bus_wdata = fill_md ? fill_q : rd_buf_q;
        busy      = (state_q != ST_IDLE);
        irq       = irq_q;
    end

    // ---------------- assertions ----------------
    // R4: fill mode issues write beats only
    a_r4_fill_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && ctrl_q.src_mode == AM_NONE) |-> bus_we);

    // R5: request released after the last write of a block
    a_r5_block_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_grant && blk_left_q == RUN_W'(1)) |=> !bus_req);

    // R8: repeat mode stays armed unless software writes the control word
    a_r8_stay_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_q.repeat_md && !ctrl_q.immed && !wr_ctrl) |=> busy);

    // R12: interrupt is a single-cycle pulse coinciding with busy falling
    a_r12_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    a_r12_irq_on_retire: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && $past(busy)));

    // R13: an ungranted beat is held unchanged
    a_r13_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_grant && !reg_we) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)));

endmodule

// File: tb/test_dma_chan_seq.sv
`timescale 1ns/1ps
module test_dma_chan_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [15:0] trig_vec = '0;
    logic        bus_req, bus_we, busy, irq;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_grant = 1'b1;
    logic        stall_en = 1'b0;
    logic        mon_clr = 1'b0;
    bit          finished = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    dma_chan_seq i_dma_chan_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .trig_vec  (trig_vec),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_grant (bus_grant),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .irq       (irq)
    );

    // memory model: read data is a fixed function of the address
    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction
    assign bus_rdata = mem_val(bus_addr);

    // grant pattern
    int cyc = 0;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        bus_grant <= !stall_en || (cyc % 3 == 0);
    end

    // bus monitor
    logic [31:0] wa [64];
    logic [31:0] wd [64];
    logic [31:0] ra [64];
    int gaps [16];
    int wr_n, rd_n, gap_n, low_run, irq_n;
    bit seen, misal;

    always @(posedge clk) begin
        if (mon_clr) begin
            wr_n = 0; rd_n = 0; gap_n = 0; low_run = 0; irq_n = 0;
            seen = 1'b0; misal = 1'b0;
        end else begin
            if (bus_req) begin
                if (seen && low_run > 0 && gap_n < 16) begin
                    gaps[gap_n] = low_run;
                    gap_n++;
                end
                seen = 1'b1;
                low_run = 0;
                if (bus_addr[1:0] != 2'b00) misal = 1'b1;
                if (bus_grant) begin
                    if (bus_we) begin
                        if (wr_n < 64) begin wa[wr_n] = bus_addr; wd[wr_n] = bus_wdata; end
                        wr_n++;
                    end else begin
                        if (rd_n < 64) ra[rd_n] = bus_addr;
                        rd_n++;
                    end
                end
            end else if (seen) begin
                low_run++;
            end
            if (irq) irq_n++;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic clear_mon();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk); trig_vec[idx] = 1'b1;
        @(negedge clk); trig_vec = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [31:0] EN  = 32'h8000_0000;
    localparam logic [31:0] IEN = 32'h4000_0000;
    localparam logic [31:0] REP = 32'h2000_0000;
    localparam logic [31:0] IMM = 32'h1000_0000;

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 bus_req", 32'(bus_req), 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_immediate_copy();
        clear_mon();
        stall_en = 1'b1;
        wr_reg(0, 32'h0000_0002);
        wr_reg(1, 32'h0000_0200);
        wr_reg(3, 6);
        wr_reg(2, 1);
        wr_reg(4, 0);
        wr_reg(6, EN | IEN | REP | IMM | (32'd2 << 16));
        chk("R7 no request in load cycle", 32'(bus_req), 0);
        @(negedge clk);
        chk("R7 request two cycles after write", 32'(bus_req), 1);
        wait_idle();
        settle(3);
        stall_en = 1'b0;
        chk("R7 words moved", wr_n, 6);
        chk("R13 reads", rd_n, 6);
        chk("R2 first read aligned", ra[0], 32'h0);
        chk("R2 no misaligned beat", 32'(misal), 0);
        for (int k = 0; k < 6; k++) begin
            chk("R3 inc dst addr", wa[k], 32'h200 + 32'(4 * k));
            chk("R13 data", wd[k], mem_val(32'(4 * k)));
        end
        chk("R5 one block boundary", gap_n, 1);
        chk("R6 zero wait gap", gaps[0], 1);
        chk("R7 busy cleared", 32'(busy), 0);
        chk("R12 one irq", irq_n, 1);
    endtask

    task automatic t_dec_fixed();
        clear_mon();
        wr_reg(0, 32'h0000_00FC);
        wr_reg(1, 32'h0000_0300);
        wr_reg(3, 4);
        wr_reg(6, EN | IMM | (32'd1 << 13) | (32'd2 << 10));
        wait_idle();
        settle(3);
        chk("R3 dec/fix count", wr_n, 4);
        for (int k = 0; k < 4; k++) begin
            chk("R3 dec src", ra[k], 32'hFC - 32'(4 * k));
            chk("R3 fixed dst", wa[k], 32'h300);
            chk("R3 dec data", wd[k], mem_val(32'hFC - 32'(4 * k)));
        end
        chk("R5 single-word blocks", gap_n, 3);
        chk("R12 no irq when disabled", irq_n, 0);

        clear_mon();
        wr_reg(0, 32'h0000_0010);
        wr_reg(1, 32'h0000_033C);
        wr_reg(3, 3);
        wr_reg(6, EN | IMM | (32'd2 << 13) | (32'd1 << 10));
        wait_idle();
        settle(3);
        chk("R3 fix/dec count", wr_n, 3);
        for (int k = 0; k < 3; k++) begin
            chk("R3 fixed src", ra[k], 32'h10);
            chk("R3 dec dst", wa[k], 32'h33C - 32'(4 * k));
        end
    endtask

    task automatic t_fill();
        clear_mon();
        wr_reg(5, 32'hA5A5_1234);
        wr_reg(1, 32'h0000_0380);
        wr_reg(3, 5);
        wr_reg(6, EN | IMM | (32'd3 << 13) | (32'd1 << 16));
        wait_idle();
        settle(3);
        chk("R4 no reads", rd_n, 0);
        chk("R4 writes", wr_n, 5);
        for (int k = 0; k < 5; k++) begin
            chk("R4 fill data", wd[k], 32'hA5A5_1234);
            chk("R4 fill addr", wa[k], 32'h380 + 32'(4 * k));
        end
        chk("R5 blocks 2,2,1", gap_n, 2);
    endtask

    task automatic t_gap();
        int n_v [4] = '{3, 2, 1, 5};
        int p_v [4] = '{2, 1, 3, 0};
        int d_v [4] = '{16, 4, 64, 1};
        for (int s = 0; s < 4; s++) begin
            clear_mon();
            wr_reg(4, (32'(p_v[s]) << 16) | 32'(n_v[s]));
            wr_reg(1, 32'h0000_0100);
            wr_reg(3, 4);
            wr_reg(6, EN | IMM | (32'd3 << 13) | (32'd1 << 16));
            wait_idle();
            settle(3);
            chk("R6 gap count", gap_n, 1);
            chk("R6 gap length", gaps[0], 32'(1 + n_v[s] * d_v[s]));
        end
        wr_reg(4, 0);
    endtask

    task automatic t_repeat();
        clear_mon();
        wr_reg(0, 32'h0000_0080);
        wr_reg(1, 32'h0000_02A0);
        wr_reg(3, 2);
        wr_reg(6, EN | IEN | REP | (32'd5 << 24) | (32'd1 << 16));
        settle(2);
        pulse(4);
        settle(30);
        chk("R10 other trigger ignored", wr_n, 0);
        pulse(5);
        settle(30);
        chk("R8 first run", wr_n, 2);
        chk("R8 still busy", 32'(busy), 1);
        pulse(5);
        settle(30);
        chk("R8 second run", wr_n, 4);
        chk("R8 still busy after 2", 32'(busy), 1);
        chk("R11 no reload dst", wa[2], 32'h2A8);
        chk("R11 no reload src", wd[3], mem_val(32'h8C));
        wr_reg(6, IEN);
        settle(3);
        chk("R12 abort clears busy", 32'(busy), 0);
        chk("R12 no irq on abort", irq_n, 0);
    endtask

    task automatic t_counted();
        clear_mon();
        wr_reg(0, 32'h0000_0040);
        wr_reg(1, 32'h0000_0280);
        wr_reg(3, 4);
        wr_reg(2, 8);
        wr_reg(4, 20);
        wr_reg(6, EN | IEN | (32'd9 << 24) | (32'd1 << 12));
        settle(2);
        pulse(9);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (wr_n >= 1) break;
        end
        pulse(9);   // arrives mid-run, during the wait
        settle(150);
        chk("R10 mid-run trigger ignored", wr_n, 4);
        chk("R9 busy before budget", 32'(busy), 1);
        chk("R12 no irq yet", irq_n, 0);
        pulse(9);
        settle(150);
        chk("R9 total words", wr_n, 8);
        chk("R9 retired", 32'(busy), 0);
        chk("R12 irq once", irq_n, 1);
        for (int k = 4; k < 8; k++) begin
            chk("R11 dst reloaded", wa[k], 32'h280 + 32'(4 * (k - 4)));
            chk("R11 src continues", wd[k], mem_val(32'h40 + 32'(4 * k)));
        end
        wr_reg(4, 0);
    endtask

    task automatic t_src_reload();
        clear_mon();
        wr_reg(0, 32'h0000_0060);
        wr_reg(1, 32'h0000_02C0);
        wr_reg(3, 2);
        wr_reg(6, EN | REP | (32'd3 << 24) | (32'd1 << 15) | (32'd1 << 16));
        settle(2);
        pulse(3);
        settle(30);
        pulse(3);
        settle(30);
        chk("R11 words", wr_n, 4);
        for (int k = 0; k < 4; k++) begin
            chk("R11 dst continues", wa[k], 32'h2C0 + 32'(4 * k));
            chk("R11 src reloaded", wd[k], mem_val(32'h60 + 32'(4 * (k % 2))));
        end
        wr_reg(6, 0);
        settle(3);
    endtask

    task automatic t_budget_no_irq();
        clear_mon();
        wr_reg(5, 32'h0BAD_F00D);
        wr_reg(1, 32'h0000_0100);
        wr_reg(3, 3);
        wr_reg(2, 5);
        wr_reg(6, EN | (32'd0 << 24) | (32'd3 << 13));
        settle(2);
        pulse(0);
        settle(40);
        chk("R9 partial budget keeps busy", 32'(busy), 1);
        pulse(0);
        settle(40);
        chk("R9 overshoot retires", 32'(busy), 0);
        chk("R9 words", wr_n, 6);
        chk("R12 no irq without enable", irq_n, 0);
    endtask

    // ---------------- main ----------------
    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        settle(2);
        t_reset();
        t_immediate_copy();
        t_dec_fixed();
        t_fill();
        t_gap();
        t_repeat();
        t_counted();
        t_src_reload();
        t_budget_no_irq();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule